// File: doc/BRIEF.md
# Data Memory Access Router with Wait States

This block sits between a microcontroller core and its data-memory resources. It takes the core's load and store requests, each addressed over a 24-bit pointer, and sends each one either to a 2 KB on-chip RAM or to an external bus. When a mapping bit is set, the lowest 2 KB of the address space is served on chip. Every other address goes to the external bus. When the bit is clear, every address goes to the external bus.

An on-chip access leaves the external address/data lines and both strobes idle, and a "pins free" flag tells the pin multiplexer that the pins may serve as general I/O. An external access drives the address, the write data and an active-low read or write strobe. Its length is 4+n machine cycles, where n is a 3-bit wait-state setting. A machine cycle lasts `MC_CLKS` clocks.

The core uses a simple handshake. It raises `req` together with the address, direction and write data, and holds them until `rdy` pulses. Configuration is loaded through `cfg_we`. The configuration is captured when an access starts, so changing it during an access cannot alter that access.

Top module: `xr_router`

## Requirements
- R1: After reset, the mapping bit and the wait-state value are 0, `rdy` is low, `ext_rd_n` and `ext_wr_n` are high, `ext_drive` is low and `pins_free` is high.
- R2: With the mapping bit clear, every access, including addresses 000000h to 0007FFh, goes to the external bus (`ext_drive` high for the whole access).
- R3: With the mapping bit set, an access to 000000h..0007FFh is served by on-chip RAM. For the whole access `ext_rd_n`=`ext_wr_n`=1, `ext_drive`=0 and `pins_free`=1.
- R4: With the mapping bit set, addresses 000800h..FFFFFFh go to the external bus, and `ext_addr` carries all 24 address bits, held stable for the whole access.
- R5: An external access lasts (4+n)*MC_CLKS clocks, counted from the clock edge that accepts `req` up to and including the cycle in which `rdy` is high, for each n in 0..7.
- R6: An on-chip access lasts 4*MC_CLKS clocks, whatever the wait-state value.
- R7: `rdy` is high for exactly one cycle per access, and `rdata` is valid in that cycle. An external read returns the `ext_rdata` present in the cycle before `rdy`. An on-chip read returns the byte most recently written to that on-chip address.
- R8: The mapping bit and wait-state value are taken when an access is accepted. A `cfg_we` write during an access affects only later accesses.
- R9: In an external access, the strobe (`ext_rd_n` for reads, `ext_wr_n` for writes, both active low) is asserted in every cycle except the first and the last (the `rdy` cycle). The other strobe stays high. `ext_wdata` carries the write data for the whole of a write.
- R10: A `req` held high while busy does not restart or shorten the access. The cycle after `rdy` is always idle (`rdy` low, `ext_drive` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the configuration fields below |
| cfg_map_in | input | 1 | Mapping bit: 1 maps the low 2 KB to on-chip RAM |
| cfg_wait_in | input | 3 | Wait-state value n |
| req | input | 1 | Access request, held until `rdy` |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Store data |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Load data, valid while `rdy` is high |
| ext_addr | output | 24 | External address, 0 when not driven |
| ext_wdata | output | 8 | External write data, 0 when not driven |
| ext_rdata | input | 8 | External read data |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| ext_drive | output | 1 | External address/data lines are driven |
| pins_free | output | 1 | External pins are available as general I/O |

## Verification
The hardest case to reach from the ports is a configuration write that lands in the middle of an access. Because of the request handshake, software would normally reprogram only between accesses. The stimulus therefore drives `cfg_we` in the second cycle of an access and checks two things: that access keeps its original length, and the next access uses the new one. The other difficult cases are the exact ends of the 2 KB window (0007FFh, 000800h and FFFFFFh) under both settings of the mapping bit. These are hit by directed accesses before the random phase starts. The random phase biases its addresses toward the low 4 KB.

// File: rtl/xr_pkg.sv
package xr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } st_e;

    localparam int BASE_MC = 4;

    // clock count of one access from accept edge through the rdy cycle
    function automatic int access_len(input logic is_ext, input int wait_n, input int mc);
        return (is_ext ? (BASE_MC + wait_n) : BASE_MC) * mc;
    endfunction

endpackage

// File: rtl/xr_decode.sv
module xr_decode #(
    parameter int ADDR_W      = 24,
    parameter int LOCAL_BYTES = 2048
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              map_en,
    output logic              is_local
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(LOCAL_BYTES);

    always_comb begin
        is_local = map_en && (addr < LIMIT);
    end
endmodule

// File: rtl/xr_ram.sv
module xr_ram #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
        if (en && !we) begin
            rdata_q <= mem[addr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/xr_strobe.sv
module xr_strobe #(
    parameter int CW = 5
) (
    input  logic          busy,
    input  logic          is_ext,
    input  logic          we,
    input  logic          first,
    input  logic [CW-1:0] cnt,
    output logic          ext_active,
    output logic          rd_n,
    output logic          wr_n
);
    logic mid;

    always_comb begin
        ext_active = busy && is_ext;
        mid        = ext_active && !first && (cnt != '0);
        rd_n       = !(mid && !we);
        wr_n       = !(mid && we);
    end
endmodule

// File: rtl/xr_router.sv
module xr_router #(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 8,
    parameter int LOCAL_BYTES = 2048,
    parameter int WAIT_W      = 3,
    parameter int MC_CLKS     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_map_in,
    input  logic [WAIT_W-1:0] cfg_wait_in,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rdy,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic              ext_drive,
    output logic              pins_free
);
    import xr_pkg::*;

    localparam int MAX_LEN = (BASE_MC + (1 << WAIT_W) - 1) * MC_CLKS;
    localparam int CW      = $clog2(MAX_LEN + 1);
    localparam int LAW     = $clog2(LOCAL_BYTES);

    typedef struct packed {
        st_e               st;
        logic              first;
        logic              is_ext;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] ext_cap;
        logic              map;
        logic [WAIT_W-1:0] wait_n;
    } state_t;

    state_t state_d, state_q;

    logic              busy;
    logic              cfg_map_q;
    logic              accept;
    logic              req_local;
    logic              ext_active;
    logic [DATA_W-1:0] ram_rdata;

    assign busy      = (state_q.st == ST_BUSY);
    assign cfg_map_q = state_q.map;
    assign accept    = !busy && req;

    xr_decode #(
        .ADDR_W      (ADDR_W),
        .LOCAL_BYTES (LOCAL_BYTES)
    ) u_decode (
        .addr     (req_addr),
        .map_en   (state_q.map),
        .is_local (req_local)
    );

    xr_ram #(
        .DEPTH  (LOCAL_BYTES),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk   (clk),
        .en    (accept && req_local),
        .we    (req_we),
        .addr  (req_addr[LAW-1:0]),
        .wdata (req_wdata),
        .rdata (ram_rdata)
    );

    xr_strobe #(
        .CW (CW)
    ) u_strobe (
        .busy       (busy),
        .is_ext     (state_q.is_ext),
        .we         (state_q.we),
        .first      (state_q.first),
        .cnt        (state_q.cnt),
        .ext_active (ext_active),
        .rd_n       (ext_rd_n),
        .wr_n       (ext_wr_n)
    );

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            state_d.map    = cfg_map_in;
            state_d.wait_n = cfg_wait_in;
        end
        unique case (state_q.st)
            ST_IDLE: begin
                if (req) begin
                    state_d.st     = ST_BUSY;
                    state_d.first  = 1'b1;
                    state_d.is_ext = !req_local;
                    state_d.we     = req_we;
                    state_d.addr   = req_addr;
                    state_d.wdata  = req_wdata;
                    state_d.cnt    = CW'(access_len(!req_local, int'(state_q.wait_n), MC_CLKS) - 1);
                end
            end
            ST_BUSY: begin
                state_d.first = 1'b0;
                if (state_q.is_ext && !state_q.we && (state_q.cnt == CW'(1))) begin
                    state_d.ext_cap = ext_rdata;
                end
                if (state_q.cnt == '0) begin
                    state_d.st = ST_IDLE;
                end else begin
                    state_d.cnt = state_q.cnt - CW'(1);
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rdy       = busy && (state_q.cnt == '0);
        rdata     = state_q.is_ext ? state_q.ext_cap : ram_rdata;
        ext_drive = ext_active;
        pins_free = !ext_active;
        ext_addr  = ext_active ? state_q.addr : '0;
        ext_wdata = (ext_active && state_q.we) ? state_q.wdata : '0;
    end
endmodule

// File: rtl/xr_router_chk.sv
module xr_router_chk #(
    parameter int ADDR_W      = 24,
    parameter int LOCAL_BYTES = 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rdy,
    input logic              busy,
    input logic              cfg_map_q,
    input logic              ext_drive,
    input logic              ext_rd_n,
    input logic              ext_wr_n,
    input logic              pins_free,
    input logic [ADDR_W-1:0] ext_addr
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(LOCAL_BYTES);

    assert_rdy_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);

    assert_idle_after_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !ext_drive);

    assert_free_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pins_free |-> (ext_rd_n && ext_wr_n && !ext_drive));

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!ext_rd_n, !ext_wr_n}) <= 1);

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_drive && !rdy) |=> (ext_drive && $stable(ext_addr)));

    assert_unmapped_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && !cfg_map_q) |=> ext_drive);

    assert_mapped_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && cfg_map_q && (req_addr < LIMIT)) |=> (busy && !ext_drive));
endmodule

bind xr_router xr_router_chk #(
    .ADDR_W      (ADDR_W),
    .LOCAL_BYTES (LOCAL_BYTES)
) u_chk (.*);

// File: tb/xr_router_bench.sv
`timescale 1ns/1ps
module xr_router_bench;
    localparam int MC = 2;
    localparam int LB = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_map_in = 1'b0;
    logic [2:0]  cfg_wait_in = 3'd0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rdy;
    logic [7:0]  rdata;
    logic [23:0] ext_addr;
    logic [7:0]  ext_wdata;
    logic [7:0]  ext_rdata;
    logic        ext_rd_n, ext_wr_n, ext_drive, pins_free;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit       cur_map = 1'b0;
    int       cur_wait = 0;
    logic [7:0] model_mem [LB];
    bit         model_ok  [LB];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] ext_fn(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    assign ext_rdata = ext_fn(ext_addr);

    xr_router #(.MC_CLKS(MC)) u_xr_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_map_in(cfg_map_in),
        .cfg_wait_in(cfg_wait_in), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .rdy(rdy), .rdata(rdata), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_drive(ext_drive), .pins_free(pins_free)
    );

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic set_cfg(input bit m, input int w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_map_in = m; cfg_wait_in = 3'(w);
        @(negedge clk);
        cfg_we = 1'b0;
        cur_map = m; cur_wait = w;
    endtask

    // one access; chg=1 rewrites the configuration in its second cycle
    task automatic access(input bit we, input logic [23:0] a, input logic [7:0] wd,
                          input bit chg, input bit nm, input int nw);
        bit   is_ext = !(cur_map && (a < 24'(LB)));
        int   exp_len = (is_ext ? 4 + cur_wait : 4) * MC;
        int   k = 0;
        bit   pin_bad = 1'b0, strb_bad = 1'b0, addr_bad = 1'b0;
        bit   exp_strb;
        logic [7:0] exp_rd;
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        while (k < 40) begin
            @(posedge clk);
            @(negedge clk);
            k++;
            if (chg && k == 2) begin
                cfg_we = 1'b1; cfg_map_in = nm; cfg_wait_in = 3'(nw);
            end else begin
                cfg_we = 1'b0;
            end
            exp_strb = is_ext && k >= 2 && k <= exp_len - 1;
            if (ext_drive !== is_ext || pins_free !== !is_ext) pin_bad = 1'b1;
            if (ext_rd_n !== !(exp_strb && !we) || ext_wr_n !== !(exp_strb && we)) strb_bad = 1'b1;
            if (is_ext && (ext_addr !== a || (we && ext_wdata !== wd))) addr_bad = 1'b1;
            if (rdy === 1'b1) break;
        end
        if (chg) begin cur_map = nm; cur_wait = nw; end
        chk(k == exp_len, is_ext ? "R5" : "R6", "access length", k, exp_len);
        chk(!pin_bad, is_ext ? "R2/R4" : "R3", "routing pins", pin_bad, 0);
        chk(!strb_bad, is_ext ? "R9" : "R3", "strobe pattern", strb_bad, 0);
        chk(!addr_bad, "R4", "ext address/data", addr_bad, 0);
        if (!we) begin
            if (is_ext) begin
                exp_rd = ext_fn(a);
                chk(rdata === exp_rd, "R7", "ext read data", rdata, exp_rd);
            end else if (model_ok[a[10:0]]) begin
                exp_rd = model_mem[a[10:0]];
                chk(rdata === exp_rd, "R7", "local read data", rdata, exp_rd);
            end
        end else if (!is_ext) begin
            model_mem[a[10:0]] = wd;
            model_ok[a[10:0]]  = 1'b1;
        end
        req = 1'b0;
        cfg_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(rdy === 1'b0 && ext_drive === 1'b0, "R10", "idle after rdy", {rdy, ext_drive}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] ra;
        process::self().srandom(32'd1234);
        for (int i = 0; i < LB; i++) model_ok[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy === 1'b0 && ext_rd_n === 1'b1 && ext_wr_n === 1'b1 && ext_drive === 1'b0
            && pins_free === 1'b1, "R1", "reset outputs",
            {rdy, ext_rd_n, ext_wr_n, ext_drive, pins_free}, 5'b01101);

        // R1 reset config: low address goes external with 4 machine cycles
        access(1'b0, 24'h000010, 8'h00, 1'b0, 1'b0, 0);
        // R2 map clear: window ends external
        access(1'b1, 24'h0007FF, 8'hA5, 1'b0, 1'b0, 0);
        access(1'b0, 24'h000000, 8'h00, 1'b0, 1'b0, 0);

        // R3/R6 map set, nonzero wait: local access stays 4 machine cycles
        set_cfg(1'b1, 3);
        access(1'b1, 24'h0007FF, 8'h3C, 1'b0, 1'b0, 0);
        access(1'b1, 24'h000000, 8'hC3, 1'b0, 1'b0, 0);
        access(1'b0, 24'h0007FF, 8'h00, 1'b0, 1'b0, 0);
        access(1'b0, 24'h000000, 8'h00, 1'b0, 1'b0, 0);
        // R4 boundary and top of space
        access(1'b0, 24'h000800, 8'h00, 1'b0, 1'b0, 0);
        access(1'b1, 24'hFFFFFF, 8'h77, 1'b0, 1'b0, 0);
        access(1'b0, 24'hFFFFFF, 8'h00, 1'b0, 1'b0, 0);

        // R5 every wait value
        for (int w = 0; w < 8; w++) begin
            set_cfg(1'b1, w);
            access(1'b0, 24'h123456, 8'h00, 1'b0, 1'b0, 0);
        end

        // R8 configuration change in mid access
        set_cfg(1'b1, 0);
        access(1'b0, 24'h001000, 8'h00, 1'b1, 1'b0, 7);
        access(1'b0, 24'h000100, 8'h00, 1'b0, 1'b0, 0);
        access(1'b0, 24'h000100, 8'h00, 1'b1, 1'b1, 5);
        access(1'b0, 24'h000100, 8'h00, 1'b0, 1'b0, 0);

        // random phase
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 10) == 0) set_cfg(1'($urandom), int'($urandom % 8));
            ra = ($urandom % 2) ? 24'($urandom % 4096) : 24'($urandom);
            access(1'($urandom), ra, 8'($urandom), 1'b0, 1'b0, 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule